// File: doc/BRIEF.md
# Integer Arithmetic and Shift Unit with Condition Codes

This block is the execute-stage arithmetic unit of a small 32-bit processor. Each clock it takes two operands and a four-bit operation select. It computes one of ten operations: add, subtract, bitwise AND, bitwise OR, four kinds of shift or rotate, and a half-width multiply in unsigned and signed forms. It registers a 32-bit result together with a four-bit condition code, and both appear on the outputs one clock edge after the operands were presented.

The shift amount is taken from the whole second operand. Any value of 32 or more acts exactly like a shift by 32, so software can move a word fully out without a special case. The condition code gives the rest of the pipeline zero, carry, negative and overflow. Carry means borrow on subtraction and means the last bit moved out on a shift. Overflow on a shift reports that the sign bit changed.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result_o` and `flags_o` become all zero, whatever the other inputs are.
- R2: The condition code is packed as bit 0 = zero (result equals 0), bit 1 = carry, bit 2 = negative (copy of result bit 31), bit 3 = overflow. Z and N follow this rule for every operation.
- R3: Op code 0 (add) returns a+b mod 2^32. C is the carry out of bit 31. V is set when both operands have the same sign and the sum's sign differs.
- R4: Op code 1 (subtract) returns a-b mod 2^32. C is set when a < b unsigned (borrow). V is set when the operand signs differ and the result's sign differs from a.
- R5: Op code 2 (AND) and op code 3 (OR) return the bitwise result with C and V cleared.
- R6: Op codes 4 (logical right) and 5 (arithmetic right) shifting by n in 1..31 return a shifted right, filled with zeros or with copies of a[31] respectively. C is a[n-1], the last bit moved out.
- R7: A shift or rotate (op codes 4 to 7) by zero returns a unchanged with C = 0 and V = 0.
- R8: A shift amount b of 32 or more acts as 32. Logical right gives 0 and arithmetic right gives 32 copies of a[31], with C = a[31]. Left shift gives 0 and rotate gives a, with C = a[0].
- R9: Op codes 6 (left shift) and 7 (rotate left) by n in 1..31 return a shifted left with zero fill, or rotated left. C is a[32-n], the last bit moved past bit 31.
- R10: For op codes 4 to 7, V equals result bit 31 XOR a[31].
- R11: Op code 8 (unsigned multiply) returns the 32-bit product of a[15:0] and b[15:0] as unsigned values. Bits 31:16 of both operands are ignored, and C and V are cleared.
- R12: Op code 9 (signed multiply) returns the 32-bit product of a[15:0] and b[15:0] as two's-complement values. Bits 31:16 are ignored, and C and V are cleared.
- R13: Op codes 10 to 15 return a result of 0 with C and V cleared, so Z is set.
- R14: The result and flags for operands applied before a rising edge appear right after that edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation select (codes in R3 to R13) |
| a_i | input | 32 | First operand; value that is shifted or rotated |
| b_i | input | 32 | Second operand; shift amount for op codes 4 to 7 |
| result_o | output | 32 | Registered result |
| flags_o | output | 4 | Registered condition code {V, N, C, Z} |

## Verification
The bench aims at the shift edges first. It shifts by 0, 1, 31, 32 and far beyond 32. A unit that used only the low five bits of the amount would return the operand unchanged instead of zero or sign fill. One that forgot the zero-amount case would report a stale carry, and one that took the wrong bit for carry would fail the all-ones and single-bit patterns. For add and subtract it targets the signed wrap points 0x7FFFFFFF and 0x80000000, and the unsigned wrap at 0 and 0xFFFFFFFF. A unit that inverted the borrow sense or derived overflow from the wrong operand signs would flip C or V there. For the multiplies it puts junk in the upper operand halves and uses the most negative 16-bit value. Sign extension from the wrong width, or a product that used the full operands, would show up as a wrong high half.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and condition-code bit positions for the
// execute unit. Assumes a four-bit operation select.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_SHR  = 4'd4,
        OP_SAR  = 4'd5,
        OP_SHL  = 4'd6,
        OP_ROTL = 4'd7,
        OP_MULU = 4'd8,
        OP_MULS = 4'd9
    } alu_op_e;

    // Shift kinds passed to the shifter
    typedef enum logic [1:0] {
        SK_SHR  = 2'd0,
        SK_SAR  = 2'd1,
        SK_SHL  = 2'd2,
        SK_ROTL = 2'd3
    } shift_kind_e;

    localparam int FLAG_Z = 0;
    localparam int FLAG_C = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_W = 4;

endpackage

// File: rtl/alu_addsub.sv
// Module: adder/subtractor. Produces the sum or difference, a carry that
// reads as borrow during subtraction, and signed overflow.
// Assumes: purely combinational, W >= 2.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    // Invert the second operand for subtraction and add with carry-in
    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o   = full[W-1:0];
        carry_o = sub_i ? ~full[W] : full[W];
        ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_shift.sv
// Module: shifter/rotator. Amounts of W or more are clamped to W; an amount
// of zero leaves the operand unchanged with carry clear. Carry is the last
// bit moved out; overflow reports a change of the sign bit.
// Assumes: W is a power of two.
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  shift_kind_e  kind_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int SW = $clog2(W) + 1;

    logic [SW-1:0]        amt;
    logic [W:0]           r_wide;
    logic signed [W:0]    s_wide;
    logic [W:0]           l_wide;
    logic [W-1:0]         rot;

    // Clamp the amount so every value of W or above acts as W
    always_comb begin
        amt = (b_i >= W) ? SW'(W) : b_i[SW-1:0];
    end

    // Extended shifts keep the last bit moved out in the extra position
    always_comb begin
        r_wide = {a_i, 1'b0} >> amt;
        s_wide = $signed({a_i, 1'b0}) >>> amt;
        l_wide = {1'b0, a_i} << amt;
        rot    = (a_i << amt) | (a_i >> (W - int'(amt)));
    end

    // Select the result and carry for the requested kind
    always_comb begin
        unique case (kind_i)
            SK_SHR: begin
                res_o   = r_wide[W:1];
                carry_o = r_wide[0];
            end
            SK_SAR: begin
                res_o   = s_wide[W:1];
                carry_o = s_wide[0];
            end
            SK_SHL: begin
                res_o   = l_wide[W-1:0];
                carry_o = l_wide[W];
            end
            default: begin
                res_o   = rot;
                carry_o = (amt != '0) && rot[0];
            end
        endcase
        ovf_o = res_o[W-1] ^ a_i[W-1];
    end
endmodule

// File: rtl/alu_mul.sv
// Module: half-width multiplier. Multiplies MW-bit operands as unsigned or
// two's-complement values and fits the product to W bits.
// Assumes: the caller passes only the low MW bits of each operand.
module alu_mul #(
    parameter int W  = 32,
    parameter int MW = 16
) (
    input  logic [MW-1:0] a_i,
    input  logic [MW-1:0] b_i,
    input  logic          signed_i,
    output logic [W-1:0]  prod_o
);
    localparam int PW = 2 * MW;

    logic [PW-1:0]        p_u;
    logic signed [PW-1:0] p_s;
    logic [PW-1:0]        p_sel;

    // Form both products and pick one by mode
    always_comb begin
        p_u   = a_i * b_i;
        p_s   = $signed(a_i) * $signed(b_i);
        p_sel = signed_i ? p_s : p_u;
    end

    // Fit the product to the data width, extending the sign in signed mode
    generate
        if (PW >= W) begin : g_trunc
            assign prod_o = p_sel[W-1:0];
        end else begin : g_ext
            assign prod_o = {{(W-PW){signed_i & p_sel[PW-1]}}, p_sel};
        end
    endgenerate
endmodule

// File: rtl/alu_core.sv
// Module: execute-unit top. Selects one of ten operations, forms the four
// condition flags and registers result and flags on the rising edge.
// Assumes: synchronous active-low reset; operands stable around the edge.
module alu_core
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int MW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    output logic [W-1:0]      result_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic [W-1:0]      as_sum;
    logic              as_c;
    logic              as_v;
    logic [W-1:0]      sh_res;
    logic              sh_c;
    logic              sh_v;
    logic [W-1:0]      mul_p;
    shift_kind_e       sh_kind;
    logic [W-1:0]      nxt_res;
    logic              nxt_c;
    logic              nxt_v;
    logic [FLAG_W-1:0] nxt_flags;

    // Shifter kind comes from the low two bits of the shift op codes
    always_comb begin
        sh_kind = shift_kind_e'(op_i[1:0]);
    end

    alu_addsub #(.W(W)) u_addsub (
        .a_i     (a_i),
        .b_i     (b_i),
        .sub_i   (op_i == OP_SUB),
        .sum_o   (as_sum),
        .carry_o (as_c),
        .ovf_o   (as_v)
    );

    alu_shift #(.W(W)) u_shift (
        .a_i     (a_i),
        .b_i     (b_i),
        .kind_i  (sh_kind),
        .res_o   (sh_res),
        .carry_o (sh_c),
        .ovf_o   (sh_v)
    );

    alu_mul #(.W(W), .MW(MW)) u_mul (
        .a_i      (a_i[MW-1:0]),
        .b_i      (b_i[MW-1:0]),
        .signed_i (op_i == OP_MULS),
        .prod_o   (mul_p)
    );

    // Pick the result and the carry/overflow source for this operation
    always_comb begin
        nxt_res = '0;
        nxt_c   = 1'b0;
        nxt_v   = 1'b0;
        case (op_i)
            OP_ADD, OP_SUB: begin
                nxt_res = as_sum;
                nxt_c   = as_c;
                nxt_v   = as_v;
            end
            OP_AND:  nxt_res = a_i & b_i;
            OP_OR:   nxt_res = a_i | b_i;
            OP_SHR, OP_SAR, OP_SHL, OP_ROTL: begin
                nxt_res = sh_res;
                nxt_c   = sh_c;
                nxt_v   = sh_v;
            end
            OP_MULU, OP_MULS: nxt_res = mul_p;
            default: nxt_res = '0;
        endcase
    end

    // Pack the condition code
    always_comb begin
        nxt_flags         = '0;
        nxt_flags[FLAG_Z] = (nxt_res == '0);
        nxt_flags[FLAG_C] = nxt_c;
        nxt_flags[FLAG_N] = nxt_res[W-1];
        nxt_flags[FLAG_V] = nxt_v;
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            flags_o  <= '0;
        end else begin
            result_o <= nxt_res;
            flags_o  <= nxt_flags;
        end
    end
endmodule

// File: rtl/alu_core_chk.sv
// Module: property checker for the execute unit, bound to alu_core.
// Assumes: one-edge latency from operands to outputs.
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [W-1:0]      a_i,
    input logic [W-1:0]      b_i,
    input logic [W-1:0]      result_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic primed;
    logic rst_seen;

    // primed: outputs were loaded from live operands at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // rst_seen: previous edge had reset asserted
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R1 reset clears the outputs
    always @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            p_reset_clear_r1: assert (result_o == '0 && flags_o == '0)
                else $error("R1 outputs not cleared by reset");
        end
    end

    p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (flags_o[FLAG_Z] == (result_o == '0)));

    p_neg_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (flags_o[FLAG_N] == result_o[W-1]));

    p_add_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == OP_ADD |-> result_o == $past(a_i) + $past(b_i));

    p_logic_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == OP_AND || $past(op_i) == OP_OR)
        |-> !flags_o[FLAG_C] && !flags_o[FLAG_V]);

    p_shift_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i[3:2]) == 2'b01 && $past(b_i) == '0
        |-> result_o == $past(a_i) && !flags_o[FLAG_C] && !flags_o[FLAG_V]);

    p_big_shr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == OP_SHR && $past(b_i) >= W
        |-> result_o == '0 && flags_o[FLAG_C] == $past(a_i[W-1]));

    p_shift_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i[3:2]) == 2'b01
        |-> flags_o[FLAG_V] == (result_o[W-1] ^ $past(a_i[W-1])));

    p_mul_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == OP_MULU || $past(op_i) == OP_MULS)
        |-> !flags_o[FLAG_C] && !flags_o[FLAG_V]);

    p_undef_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) > 4'd9 |-> result_o == '0 && flags_o == 4'b0001);

endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .flags_o  (flags_o)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] a = 32'd0;
    logic [31:0] b = 32'd0;
    logic [31:0] result;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    alu_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .result_o (result),
        .flags_o  (flags)
    );

    // Reference: step-by-step model written from the requirements
    function automatic void ref_model(input logic [3:0] o, input logic [31:0] x,
                                      input logic [31:0] y, output logic [31:0] r,
                                      output logic [3:0] f);
        logic [32:0] t;
        logic c, v;
        int n;
        c = 1'b0; v = 1'b0; r = 32'd0;
        case (o)
            4'd0: begin
                t = {1'b0, x} + {1'b0, y}; r = t[31:0]; c = t[32];
                v = (x[31] == y[31]) && (r[31] != x[31]);
            end
            4'd1: begin
                r = x - y; c = (x < y);
                v = (x[31] != y[31]) && (r[31] != x[31]);
            end
            4'd2: r = x & y;
            4'd3: r = x | y;
            4'd4, 4'd5, 4'd6, 4'd7: begin
                n = (y > 32) ? 32 : int'(y);
                r = x;
                for (int i = 0; i < n; i++) begin
                    case (o)
                        4'd4: begin c = r[0];  r = {1'b0, r[31:1]}; end
                        4'd5: begin c = r[0];  r = {r[31], r[31:1]}; end
                        4'd6: begin c = r[31]; r = {r[30:0], 1'b0}; end
                        default: begin c = r[31]; r = {r[30:0], r[31]}; end
                    endcase
                end
                v = r[31] ^ x[31];
            end
            4'd8: r = {16'd0, x[15:0]} * {16'd0, y[15:0]};
            4'd9: r = {{16{x[15]}}, x[15:0]} * {{16{y[15]}}, y[15:0]};
            default: r = 32'd0;
        endcase
        f = {v, r[31], c, (r == 32'd0)};
    endfunction

    // Apply one operation, wait for the capturing edge, compare both outputs
    task automatic chk(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [31:0] er, input logic [3:0] ef, input string tag);
        @(negedge clk);
        op = o; a = x; b = y;
        @(posedge clk);
        #1;
        n_checks++;
        if (result !== er || flags !== ef) begin
            n_errors++;
            $display("FAIL %s op=%0d a=%h b=%h: got r=%h f=%b, expected r=%h f=%b",
                     tag, o, x, y, result, flags, er, ef);
        end
    endtask

    // Same as chk but takes the expectation from the reference model
    task automatic chk_ref(input logic [3:0] o, input logic [31:0] x,
                           input logic [31:0] y, input string tag);
        logic [31:0] er;
        logic [3:0]  ef;
        ref_model(o, x, y, er, ef);
        chk(o, x, y, er, ef, tag);
    endtask

    // R1: reset dominates live operands
    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        op = 4'd0; a = 32'h0000_0005; b = 32'h0000_0006;
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (result !== 32'd0 || flags !== 4'd0) begin
            n_errors++;
            $display("FAIL R1 reset: got r=%h f=%b, expected r=0 f=0000", result, flags);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R3, R4: signed and unsigned wrap points
    task automatic t_addsub();
        chk(4'd0, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 4'b1100, "R3 signed ovf");
        chk(4'd0, 32'hFFFF_FFFF, 32'd1, 32'h0000_0000, 4'b0011, "R3 carry out");
        chk(4'd0, 32'h0000_1234, 32'h0000_4321, 32'h0000_5555, 4'b0000, "R3 plain");
        chk(4'd1, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 4'b1000, "R4 signed ovf");
        chk(4'd1, 32'h0000_0000, 32'd1, 32'hFFFF_FFFF, 4'b0110, "R4 borrow");
        chk(4'd1, 32'h0000_0009, 32'h0000_0009, 32'h0000_0000, 4'b0001, "R4 equal R2 zero");
    endtask

    // R5: bitwise ops clear C and V
    task automatic t_logic();
        chk(4'd2, 32'hF0F0_FFFF, 32'h0FF0_00FF, 32'h00F0_00FF, 4'b0000, "R5 and");
        chk(4'd3, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001, 4'b0100, "R5 or R2 neg");
        chk(4'd2, 32'h0000_1234, 32'h0000_0000, 32'h0000_0000, 4'b0001, "R5 and zero");
    endtask

    // R6, R8, R10: right shifts including clamped amounts
    task automatic t_right();
        chk(4'd4, 32'hFFFF_FFFF, 32'd1,  32'h7FFF_FFFF, 4'b1010, "R6 shr 1");
        chk(4'd4, 32'h7FFF_FFFF, 32'd31, 32'h0000_0000, 4'b0011, "R6 shr 31");
        chk(4'd4, 32'h0000_0000, 32'd1,  32'h0000_0000, 4'b0001, "R6 shr zero in");
        chk(4'd4, 32'h0000_0001, 32'd1,  32'h0000_0000, 4'b0011, "R6 shr last bit");
        chk(4'd4, 32'h8000_0000, 32'd1,  32'h4000_0000, 4'b1000, "R10 shr sign change");
        chk(4'd5, 32'h8000_0000, 32'd4,  32'hF800_0000, 4'b0100, "R6 sar 4");
        chk(4'd4, 32'hFFFF_FFFF, 32'd32, 32'h0000_0000, 4'b1011, "R8 shr 32");
        chk(4'd4, 32'hFFFF_FFFF, 32'd100, 32'h0000_0000, 4'b1011, "R8 shr 100");
        chk(4'd5, 32'hFFFF_FFFF, 32'd32, 32'hFFFF_FFFF, 4'b0110, "R8 sar 32");
        chk(4'd5, 32'h7FFF_FFFF, 32'd40, 32'h0000_0000, 4'b0001, "R8 sar 40");
        chk(4'd5, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0110, "R8 sar max amt");
    endtask

    // R7: zero amount leaves the operand and clears C, V
    task automatic t_zero_amt();
        chk(4'd4, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 4'b0100, "R7 shr 0");
        chk(4'd5, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 4'b0100, "R7 sar 0");
        chk(4'd6, 32'h8000_0001, 32'd0, 32'h8000_0001, 4'b0100, "R7 shl 0");
        chk(4'd7, 32'h1234_5678, 32'd0, 32'h1234_5678, 4'b0000, "R7 rotl 0");
    endtask

    // R9, R8, R10: left shifts and rotates
    task automatic t_left();
        chk(4'd6, 32'h0000_0035, 32'd8,  32'h0000_3500, 4'b0000, "R9 shl 8");
        chk(4'd6, 32'h4000_0000, 32'd1,  32'h8000_0000, 4'b1100, "R10 shl into sign");
        chk(4'd6, 32'h8000_0000, 32'd1,  32'h0000_0000, 4'b1011, "R10 shl out of sign");
        chk(4'd6, 32'hC000_0000, 32'd2,  32'h0000_0000, 4'b1011, "R9 shl 2 carry");
        chk(4'd6, 32'h0000_0003, 32'd33, 32'h0000_0000, 4'b0011, "R8 shl 33");
        chk(4'd7, 32'h0000_0001, 32'd31, 32'h8000_0000, 4'b1100, "R9 rotl 31");
        chk(4'd7, 32'h8000_0001, 32'd1,  32'h0000_0003, 4'b1010, "R9 rotl 1");
        chk(4'd7, 32'hA5A5_A5A5, 32'd32, 32'hA5A5_A5A5, 4'b0110, "R8 rotl 32");
    endtask

    // R11, R12: half-width multiplies ignore upper operand bits
    task automatic t_mul();
        chk(4'd8, 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFE_0001, 4'b0100, "R11 mulu max");
        chk(4'd8, 32'd23171, 32'd23171, 32'd536895241, 4'b0000, "R11 mulu mid");
        chk(4'd8, 32'hABCD_0005, 32'h1234_0007, 32'h0000_0023, 4'b0000, "R11 mulu upper ignored");
        chk(4'd9, 32'h0000_8001, 32'h0000_7FFF, 32'hC000_FFFF, 4'b0100, "R12 muls mixed");
        chk(4'd9, 32'h0000_8001, 32'h0000_8001, 32'h3FFF_0001, 4'b0000, "R12 muls neg sq");
        chk(4'd9, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 4'b0000, "R12 muls min sq");
        chk(4'd9, 32'hFFFF_0002, 32'h0000_FFFD, 32'hFFFF_FFFA, 4'b0100, "R12 muls upper ignored");
    endtask

    // R13: unused op codes
    task automatic t_undef();
        chk(4'd10, 32'h0000_0005, 32'h0000_0007, 32'h0, 4'b0001, "R13 op 10");
        chk(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 4'b0001, "R13 op 15");
    endtask

    // R14: outputs hold until the edge, then change
    task automatic t_latency();
        chk(4'd0, 32'd2, 32'd3, 32'd5, 4'b0000, "R14 setup");
        @(negedge clk);
        op = 4'd3; a = 32'h0000_00F0; b = 32'h0000_000F;
        #1;
        n_checks++;
        if (result !== 32'd5 || flags !== 4'b0000) begin
            n_errors++;
            $display("FAIL R14 before edge: got r=%h f=%b, expected r=00000005 f=0000",
                     result, flags);
        end
        @(posedge clk);
        #1;
        n_checks++;
        if (result !== 32'h0000_00FF || flags !== 4'b0000) begin
            n_errors++;
            $display("FAIL R14 after edge: got r=%h f=%b, expected r=000000ff f=0000",
                     result, flags);
        end
    endtask

    // R2..R13: pseudo-random operands against the reference model
    task automatic t_sweep();
        logic [31:0] s;
        logic [31:0] amts [8];
        amts = '{32'd0, 32'd1, 32'd15, 32'd31, 32'd32, 32'd33, 32'h0000_0100, 32'hFFFF_FFFF};
        s = 32'h1ACE_B00C;
        for (int o = 0; o < 16; o++) begin
            for (int k = 0; k < 8; k++) begin
                logic [31:0] x, y;
                s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
                x = s ^ {s[15:0], s[31:16]};
                s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
                y = (o >= 4 && o <= 7) ? amts[k] : (s * 32'h9E37_79B9);
                chk_ref(4'(o), x, y, "R2 sweep");
            end
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_addsub();
        t_logic();
        t_right();
        t_zero_amt();
        t_left();
        t_mul();
        t_undef();
        t_latency();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule